// File: doc/BRIEF.md
# Debug ID Register Read Arbiter

This block decides what happens when software reads the 32-bit debug identification register. Each cycle it takes the current exception level (0 to 3), a halted flag, and a set of configuration inputs: which of levels 2 and 3 exist, whether level 2 is enabled, whether levels 1, 2 and 3 run 32-bit or 64-bit, the trap-enable bits, a routing bit that sends general traps to level 2, and two indications for undefined handling when secure debug is disabled. From these it picks one of four outcomes: the read completes with the ID value, the instruction is undefined, a trap is taken to a target level with a syndrome class, or a 32-bit hypervisor trap is raised.

The ID value is built from parameters that give the watchpoint, breakpoint and context-aware breakpoint counts and the debug version. Level-3 presence comes from an input. The decision and the data are registered once, so every result appears one clock after its request.

Top module: `dbg_id_access`

## Requirements
- R1: All outputs are registered. The result for the inputs sampled at one rising edge shows after that edge. While reset is low, outcome, target, class and data are all zero.
- R2: When `halted_i` and `ign_trap_dbg_i` are both high, the outcome is read-ok and no trap check is made.
- R3: At exception level 3 the outcome is always read-ok.
- R4: At levels 0, 1 and 2 the first check is this: level 3 is present and 64-bit, `undef_prio_i` is high and `mon_tda_i` is high. If all hold, the outcome is undefined.
- R5: At level 0, when level 1 is 64-bit and `el1_tdcc_i` is set, the unit traps with class 0x05. The target is 2 if level 2 is enabled and 64-bit and `route_el2_i` is set. Otherwise the target is 1.
- R6: At level 0, when level 1 is 32-bit and `user_dcc_dis_i` is set, the outcome depends on level 2. If level 2 is 64-bit with routing set, the unit traps to 2 with class 0x05. If level 2 is 32-bit with routing set, it raises a hypervisor trap with class 0x00. Otherwise the outcome is undefined.
- R7: Next at level 0, if level 2 is enabled and any of `route_el2_i`, `hyp_tde_i` or `hyp_tda_i` is set, the unit acts on the width of level 2. If level 2 is 64-bit it traps to 2 with class 0x05. If level 2 is 32-bit it raises a hypervisor trap with class 0x05.
- R8: At level 1 the level-2 check of R7 uses only `hyp_tde_i` and `hyp_tda_i` and ignores routing. At level 2 only the level-3 checks apply.
- R9: The last check fires when level 3 is present and 64-bit and `mon_tda_i` is set. The outcome is undefined if `sdd_undef_i` is high. Otherwise the unit traps to 3 with class 0x05. If no check fires, the outcome is read-ok.
- R10: The ID value is laid out as follows, each count field holding its count minus one. Watchpoints sit at 31:28, breakpoints at 27:24 and context-aware breakpoints at 23:20. The version is at 19:16. Bit 15 is one. Bits 14 and 12 both equal `el3_present_i`. All other bits are zero.
- R11: A count of 16 or more gives 0xF. The watchpoint and breakpoint fields are never 0x0. The context-aware field is clamped to the breakpoint field.
- R12: Outcome is one-hot: bit0 read-ok, bit1 undefined, bit2 trap, bit3 hypervisor trap. Data is zero unless the outcome is read-ok. Target and class are zero for read-ok and undefined. A hypervisor trap reports target 2.
- R13: A level that is absent, or a level 2 that is not enabled, can make no check fire. The width bit of an absent level has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_el_i | input | 2 | Exception level of the read |
| halted_i | input | 1 | Core is in halting debug |
| ign_trap_dbg_i | input | 1 | Ignore traps while halted |
| el2_present_i | input | 1 | Level 2 exists |
| el2_enabled_i | input | 1 | Level 2 enabled in current state |
| el3_present_i | input | 1 | Level 3 exists |
| el1_is32_i | input | 1 | Level 1 runs 32-bit |
| el2_is32_i | input | 1 | Level 2 runs 32-bit |
| el3_is32_i | input | 1 | Level 3 runs 32-bit |
| mon_tda_i | input | 1 | Level-3 debug access trap enable |
| el1_tdcc_i | input | 1 | Level-1 comms-channel trap enable (64-bit level 1) |
| user_dcc_dis_i | input | 1 | User comms disable (32-bit level 1) |
| hyp_tde_i | input | 1 | Hypervisor debug exception route bit |
| hyp_tda_i | input | 1 | Hypervisor debug access trap bit |
| route_el2_i | input | 1 | General traps route to level 2 |
| undef_prio_i | input | 1 | Secure-debug undefined takes top priority |
| sdd_undef_i | input | 1 | Secure-debug disable makes level-3 trap undefined |
| outcome_o | output | 4 | One-hot outcome |
| tgt_el_o | output | 2 | Trap target level |
| syn_class_o | output | 6 | Syndrome class |
| rdata_o | output | 32 | ID value on read-ok, else zero |

## Verification
Every result is due exactly one rising edge after the inputs that produce it. The bench drives a new request on the falling edge. It then waits for the next rising edge and samples a couple of nanoseconds later, so each check sees the registered answer to that request and nothing from its neighbours. Checks of priority change one bit at a time from a known state, so each expected outcome follows from a single rule. A second instance with extreme count parameters covers the field saturation and clamping.

// File: rtl/dbg_id_pkg.sv
package dbg_id_pkg;

    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_READ  = 4'b0001,
        OUT_UNDEF = 4'b0010,
        OUT_TRAP  = 4'b0100,
        OUT_HYP   = 4'b1000
    } outcome_e;

    localparam logic [5:0] CLS_DBG  = 6'h05;
    localparam logic [5:0] CLS_UDCC = 6'h00;

    typedef struct packed {
        logic [1:0] cur_el;
        logic       halted;
        logic       ign_trap;
        logic       el2_present;
        logic       el2_enabled;
        logic       el3_present;
        logic       el1_is32;
        logic       el2_is32;
        logic       el3_is32;
        logic       mon_tda;
        logic       el1_tdcc;
        logic       user_dcc_dis;
        logic       hyp_tde;
        logic       hyp_tda;
        logic       route_el2;
        logic       undef_prio;
        logic       sdd_undef;
    } req_t;

    typedef struct packed {
        outcome_e    outcome;
        logic [1:0]  tgt;
        logic [5:0]  cls;
        logic [31:0] data;
    } resp_t;

    // count-minus-one with saturation at 15 and a lower floor
    function automatic logic [3:0] count_field(int unsigned n, int unsigned floor_v);
        int unsigned f;
        f = (n == 0) ? 0 : n - 1;
        if (f > 15) f = 15;
        if (f < floor_v) f = floor_v;
        return 4'(f);
    endfunction

endpackage

// File: rtl/dbg_id_value.sv
module dbg_id_value
    import dbg_id_pkg::*;
#(
    parameter int unsigned NUM_WP  = 4,
    parameter int unsigned NUM_BP  = 6,
    parameter int unsigned NUM_CTX = 2,
    parameter logic [3:0]  DBG_VER = 4'hB
) (
    input  logic        el3_present_i,
    output logic [31:0] id_o
);
    localparam logic [3:0] WP_F    = count_field(NUM_WP, 1);
    localparam logic [3:0] BP_F    = count_field(NUM_BP, 1);
    localparam logic [3:0] CTX_RAW = count_field(NUM_CTX, 0);
    localparam logic [3:0] CTX_F   = (CTX_RAW > BP_F) ? BP_F : CTX_RAW;

    assign id_o = {WP_F, BP_F, CTX_F, DBG_VER, 1'b1, el3_present_i,
                   1'b0, el3_present_i, 12'h000};
endmodule

// File: rtl/dbg_access_decide.sv
module dbg_access_decide
    import dbg_id_pkg::*;
(
    input  req_t        req_i,
    input  logic [31:0] id_i,
    output resp_t       resp_o
);
    logic el3_64, el2_on, el2_64, el2_32, el1_64;
    resp_t r;

    assign el3_64 = req_i.el3_present && !req_i.el3_is32;
    assign el2_on = req_i.el2_present && req_i.el2_enabled;
    assign el2_64 = el2_on && !req_i.el2_is32;
    assign el2_32 = el2_on && req_i.el2_is32;
    assign el1_64 = !req_i.el1_is32;

    always_comb begin
        r = '{outcome: OUT_READ, tgt: 2'd0, cls: 6'd0, data: 32'd0};
        if (req_i.halted && req_i.ign_trap) begin
            r.outcome = OUT_READ;
        end else if (req_i.cur_el == 2'd3) begin
            r.outcome = OUT_READ;
        end else if (el3_64 && req_i.undef_prio && req_i.mon_tda) begin
            r.outcome = OUT_UNDEF;
        end else if (req_i.cur_el == 2'd0 && el1_64 && req_i.el1_tdcc) begin
            r.outcome = OUT_TRAP;
            r.cls     = CLS_DBG;
            r.tgt     = (el2_64 && req_i.route_el2) ? 2'd2 : 2'd1;
        end else if (req_i.cur_el == 2'd0 && !el1_64 && req_i.user_dcc_dis) begin
            if (el2_64 && req_i.route_el2) begin
                r.outcome = OUT_TRAP;
                r.tgt     = 2'd2;
                r.cls     = CLS_DBG;
            end else if (el2_32 && req_i.route_el2) begin
                r.outcome = OUT_HYP;
                r.tgt     = 2'd2;
                r.cls     = CLS_UDCC;
            end else begin
                r.outcome = OUT_UNDEF;
            end
        end else if (el2_on && (req_i.hyp_tde || req_i.hyp_tda ||
                     (req_i.cur_el == 2'd0 && req_i.route_el2)) &&
                     req_i.cur_el != 2'd2) begin
            r.outcome = el2_64 ? OUT_TRAP : OUT_HYP;
            r.tgt     = 2'd2;
            r.cls     = CLS_DBG;
        end else if (el3_64 && req_i.mon_tda) begin
            if (req_i.sdd_undef) begin
                r.outcome = OUT_UNDEF;
            end else begin
                r.outcome = OUT_TRAP;
                r.tgt     = 2'd3;
                r.cls     = CLS_DBG;
            end
        end
        if (r.outcome == OUT_READ) r.data = id_i;
    end

    assign resp_o = r;
endmodule

// File: rtl/dbg_id_access.sv
module dbg_id_access
    import dbg_id_pkg::*;
#(
    parameter int unsigned NUM_WP  = 4,
    parameter int unsigned NUM_BP  = 6,
    parameter int unsigned NUM_CTX = 2,
    parameter logic [3:0]  DBG_VER = 4'hB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cur_el_i,
    input  logic        halted_i,
    input  logic        ign_trap_dbg_i,
    input  logic        el2_present_i,
    input  logic        el2_enabled_i,
    input  logic        el3_present_i,
    input  logic        el1_is32_i,
    input  logic        el2_is32_i,
    input  logic        el3_is32_i,
    input  logic        mon_tda_i,
    input  logic        el1_tdcc_i,
    input  logic        user_dcc_dis_i,
    input  logic        hyp_tde_i,
    input  logic        hyp_tda_i,
    input  logic        route_el2_i,
    input  logic        undef_prio_i,
    input  logic        sdd_undef_i,
    output logic [3:0]  outcome_o,
    output logic [1:0]  tgt_el_o,
    output logic [5:0]  syn_class_o,
    output logic [31:0] rdata_o
);
    req_t        req;
    logic [31:0] id_val;
    resp_t       dec;
    resp_t       st_d, st_q;

    assign req = '{cur_el: cur_el_i, halted: halted_i, ign_trap: ign_trap_dbg_i,
                   el2_present: el2_present_i, el2_enabled: el2_enabled_i,
                   el3_present: el3_present_i, el1_is32: el1_is32_i,
                   el2_is32: el2_is32_i, el3_is32: el3_is32_i,
                   mon_tda: mon_tda_i, el1_tdcc: el1_tdcc_i,
                   user_dcc_dis: user_dcc_dis_i, hyp_tde: hyp_tde_i,
                   hyp_tda: hyp_tda_i, route_el2: route_el2_i,
                   undef_prio: undef_prio_i, sdd_undef: sdd_undef_i};

    dbg_id_value #(
        .NUM_WP(NUM_WP), .NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .DBG_VER(DBG_VER)
    ) u_idv (
        .el3_present_i(el3_present_i),
        .id_o         (id_val)
    );

    dbg_access_decide u_dec (
        .req_i (req),
        .id_i  (id_val),
        .resp_o(dec)
    );

    always_comb begin
        st_d = dec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{outcome: OUT_NONE, tgt: 2'd0, cls: 6'd0, data: 32'd0};
        else        st_q <= st_d;
    end

    assign outcome_o   = st_q.outcome;
    assign tgt_el_o    = st_q.tgt;
    assign syn_class_o = st_q.cls;
    assign rdata_o     = st_q.data;
endmodule

// File: rtl/dbg_id_access_chk.sv
module dbg_id_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cur_el_i,
    input logic        halted_i,
    input logic        ign_trap_dbg_i,
    input logic [3:0]  outcome_o,
    input logic [1:0]  tgt_el_o,
    input logic [5:0]  syn_class_o,
    input logic [31:0] rdata_o
);
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $countones(outcome_o) == 1);
    a_r12_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome_o != 4'b0001) |-> rdata_o == 32'd0);
    a_r12_hyp_target: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome_o == 4'b1000) |-> tgt_el_o == 2'd2);
    a_r9_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome_o == 4'b0100) |-> syn_class_o == 6'h05);
    a_r3_el3_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_el_i == 2'd3) |=> outcome_o == 4'b0001);
    a_r2_halt_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_i && ign_trap_dbg_i) |=> outcome_o == 4'b0001);
    a_r10_bit15: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome_o == 4'b0001) |-> rdata_o[15]);
    a_r11_ctx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[23:20] <= rdata_o[27:24]);
endmodule

bind dbg_id_access dbg_id_access_chk u_chk (.*);

// File: tb/dbg_id_access_tb.sv
module dbg_id_access_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cur_el;
    logic halted, ign, el2_p, el2_en, el3_p, el1_32, el2_32, el3_32;
    logic mon_tda, tdcc, udcc, tde, tda, route, uprio, sdd;
    logic [3:0]  outc, outc_s;
    logic [1:0]  tgt, tgt_s;
    logic [5:0]  cls, cls_s;
    logic [31:0] data, data_s;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [3:0] OK = 4'b0001, UND = 4'b0010, TRP = 4'b0100, HYP = 4'b1000;
    localparam logic [31:0] ID_EL3 = 32'h351B_D000;
    localparam logic [31:0] ID_NO3 = 32'h351B_8000;

    always #5 clk = ~clk;

    dbg_id_access u_dut (
        .clk(clk), .rst_n(rst_n), .cur_el_i(cur_el), .halted_i(halted),
        .ign_trap_dbg_i(ign), .el2_present_i(el2_p), .el2_enabled_i(el2_en),
        .el3_present_i(el3_p), .el1_is32_i(el1_32), .el2_is32_i(el2_32),
        .el3_is32_i(el3_32), .mon_tda_i(mon_tda), .el1_tdcc_i(tdcc),
        .user_dcc_dis_i(udcc), .hyp_tde_i(tde), .hyp_tda_i(tda),
        .route_el2_i(route), .undef_prio_i(uprio), .sdd_undef_i(sdd),
        .outcome_o(outc), .tgt_el_o(tgt), .syn_class_o(cls), .rdata_o(data));

    dbg_id_access #(.NUM_WP(20), .NUM_BP(1), .NUM_CTX(9), .DBG_VER(4'h6)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .cur_el_i(cur_el), .halted_i(halted),
        .ign_trap_dbg_i(ign), .el2_present_i(el2_p), .el2_enabled_i(el2_en),
        .el3_present_i(el3_p), .el1_is32_i(el1_32), .el2_is32_i(el2_32),
        .el3_is32_i(el3_32), .mon_tda_i(mon_tda), .el1_tdcc_i(tdcc),
        .user_dcc_dis_i(udcc), .hyp_tde_i(tde), .hyp_tda_i(tda),
        .route_el2_i(route), .undef_prio_i(uprio), .sdd_undef_i(sdd),
        .outcome_o(outc_s), .tgt_el_o(tgt_s), .syn_class_o(cls_s), .rdata_o(data_s));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic base();
        @(negedge clk);
        cur_el = 2'd0; halted = 0; ign = 0; el2_p = 1; el2_en = 1; el3_p = 1;
        el1_32 = 0; el2_32 = 0; el3_32 = 0; mon_tda = 0; tdcc = 0; udcc = 0;
        tde = 0; tda = 0; route = 0; uprio = 0; sdd = 0;
    endtask

    // waits for the registering edge, then compares all outputs
    task automatic expect_res(string tag, logic [3:0] eo, logic [1:0] et,
                              logic [5:0] ec, logic [31:0] ed);
        @(posedge clk); #2;
        chk({tag, " outcome"}, 64'(outc), 64'(eo));
        chk({tag, " target"}, 64'(tgt), 64'(et));
        chk({tag, " class"}, 64'(cls), 64'(ec));
        chk({tag, " data R12"}, 64'(data), 64'(ed));
    endtask

    task automatic t_reset();
        #2;
        chk("R1 reset outcome", 64'(outc), 64'(0));
        chk("R1 reset data", 64'(data), 64'(0));
    endtask

    task automatic t_id();
        base(); expect_res("R10 id el3", OK, 0, 0, ID_EL3);
        base(); el3_p = 0; expect_res("R10 id no el3", OK, 0, 0, ID_NO3);
        chk("R11 saturate/floor/clamp", 64'(data_s), 64'(32'hF116_8000));
    endtask

    task automatic t_halt_el3();
        base(); halted = 1; ign = 1; uprio = 1; mon_tda = 1;
        expect_res("R2 halted ignore", OK, 0, 0, ID_EL3);
        base(); halted = 1; uprio = 1; mon_tda = 1;
        expect_res("R4 halted alone", UND, 0, 0, 0);
        base(); cur_el = 3; uprio = 1; mon_tda = 1; tde = 1;
        expect_res("R3 el3 read", OK, 0, 0, ID_EL3);
    endtask

    task automatic t_prio();
        base(); cur_el = 1; uprio = 1; mon_tda = 1; tde = 1;
        expect_res("R4 prio undef el1", UND, 0, 0, 0);
        base(); cur_el = 0; uprio = 1; mon_tda = 1; tdcc = 1;
        expect_res("R4 prio over tdcc", UND, 0, 0, 0);
        base(); cur_el = 1; uprio = 1; mon_tda = 1; el3_32 = 1;
        expect_res("R13 el3 32-bit no check", OK, 0, 0, ID_EL3);
    endtask

    task automatic t_tdcc();
        base(); tdcc = 1; expect_res("R5 tdcc to el1", TRP, 1, 5, 0);
        base(); tdcc = 1; route = 1; expect_res("R5 tdcc to el2", TRP, 2, 5, 0);
        base(); tdcc = 1; route = 1; el2_32 = 1; expect_res("R5 tdcc el2 32", TRP, 1, 5, 0);
    endtask

    task automatic t_udcc();
        base(); el1_32 = 1; udcc = 1; expect_res("R6 udcc undef", UND, 0, 0, 0);
        base(); el1_32 = 1; udcc = 1; route = 1; expect_res("R6 udcc el2 64", TRP, 2, 5, 0);
        base(); el1_32 = 1; udcc = 1; route = 1; el2_32 = 1;
        expect_res("R6 udcc hyp", HYP, 2, 0, 0);
    endtask

    task automatic t_el2();
        base(); tde = 1; expect_res("R7 el0 tde", TRP, 2, 5, 0);
        base(); tda = 1; el2_32 = 1; expect_res("R7 el0 tda hyp", HYP, 2, 5, 0);
        base(); route = 1; expect_res("R7 el0 route", TRP, 2, 5, 0);
        base(); cur_el = 1; route = 1; expect_res("R8 el1 ignores route", OK, 0, 0, ID_EL3);
        base(); cur_el = 1; tda = 1; expect_res("R8 el1 tda", TRP, 2, 5, 0);
        base(); cur_el = 2; tde = 1; tdcc = 1; expect_res("R8 el2 skips", OK, 0, 0, ID_EL3);
    endtask

    task automatic t_el3();
        base(); mon_tda = 1; expect_res("R9 trap el3", TRP, 3, 5, 0);
        base(); cur_el = 2; mon_tda = 1; sdd = 1; expect_res("R9 sdd undef", UND, 0, 0, 0);
    endtask

    task automatic t_absent();
        base(); el2_p = 0; tde = 1; expect_res("R13 el2 absent", OK, 0, 0, ID_EL3);
        base(); el2_en = 0; tda = 1; expect_res("R13 el2 disabled", OK, 0, 0, ID_EL3);
        base(); el3_p = 0; mon_tda = 1; uprio = 1; expect_res("R13 el3 absent", OK, 0, 0, ID_NO3);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        base();
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1;
        t_id();
        t_halt_el3();
        t_prio();
        t_tdcc();
        t_udcc();
        t_el2();
        t_el3();
        t_absent();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule